// File: doc/BRIEF.md
# Peripheral Request to Channel Router

This block routes up to 75 peripheral request lines to a smaller set of DMA channels. A table of 8-bit map entries, one per request line, says which channel a line drives and whether the mapping is in force. Software reaches the entries through a simple register port, and they sit in two address windows. Lines 0 to 63 live in the low window and lines 64 to 74 in the high window.

Each cycle the block compares every request line with a registered copy of itself. For every mapped rising or falling transition it produces a one-cycle status strobe on the target channel. There are three strobes: request-after-stop set, request-after-stop clear and end-of-receive set. The block also gives a per-channel request-active level. The transfer engine and arbitration between lines that share a channel are outside this block. When several mapped lines share a channel, the active level is the OR of their levels. All ports are plain control and status pins. Nothing in the block flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `req_router`

## Requirements
- R1: A map entry holds the channel number in bits 4:0 and the valid flag in bit 7. Bits 6:5 are not stored and read back as zero, so writing 0xFF reads back 0x9F.
- R2: The entry for line n, with n from 0 to 63, is at byte address 0x100 + 4*n.
- R3: The entry for line n, with n from 64 to 74, is at byte address 0x1100 + 4*(n-64). A write to an address outside both windows changes no entry, and a read there returns 0.
- R4: After reset every map entry reads 0, and all channel outputs and the error output are low.
- R5: A request line whose entry has the valid flag clear causes no change on any channel output.
- R6: The `ch_active` bit of a channel equals the OR of the levels of its mapped lines, one cycle after the input level is sampled.
- R7: A mapped line that rises while its channel is inactive pulses `ras_set` for that channel for one cycle, one cycle after the rise is sampled.
- R8: A mapped line that rises while its channel is already active, or any mapped falling edge, pulses `ras_clr` for one cycle, unless `ras_set` pulses for that channel in the same cycle.
- R9: A mapped line that falls while its channel is active pulses `eor_set` for one cycle, one cycle after the fall is sampled.
- R10: A write of an entry with the valid flag set and a channel number of NUM_CH or more pulses `map_err` in the cycle after the write. The entry is still stored, and a request on that line drives no channel output.
- R11: A request line held at one level produces exactly one event for each transition, never repeated strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Map entry write strobe |
| reg_addr | input | 16 | Byte address of the map entry |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| map_err | output | 1 | Pulse: a valid entry named a channel that does not exist |
| req_in | input | NUM_REQ | Peripheral request levels |
| ch_active | output | NUM_CH | Per-channel request-active level |
| ras_set | output | NUM_CH | Pulse: set the request-after-stop flag |
| ras_clr | output | NUM_CH | Pulse: clear the request-after-stop flag |
| eor_set | output | NUM_CH | Pulse: set the end-of-receive flag |

## Verification
A corrupted map entry shows up straight away on `reg_rdata`. A wrongly routed line shows up as a strobe on the wrong channel, one cycle after its transition. A stale registered copy of a request line shows up as a missing strobe, or as strobes that repeat while the level is held. A wrong channel-active state flips the choice between `ras_set` and `ras_clr`, and the next mapped rising edge exposes it. A wrong channel-active state also suppresses `eor_set` on the following falling edge.

// File: rtl/req_router_pkg.sv
package req_router_pkg;
  localparam int LOW_ENTRIES = 64;
  localparam int CH_BITS = 5;
  localparam logic [15:0] WIN_A_BASE = 16'h0100;
  localparam logic [15:0] WIN_B_BASE = 16'h1100;
endpackage

// File: rtl/req_edge.sv
module req_edge #(
  parameter int N = 75
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_ONE_RISE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]); // R11
  end
endmodule

// File: rtl/map_table.sv
module map_table
  import req_router_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [15:0]                      addr,
  input  logic [7:0]                       wdata,
  output logic [7:0]                       rdata,
  output logic                             err,
  output logic [NUM_REQ-1:0]               ent_vld,
  output logic [NUM_REQ-1:0][CH_BITS-1:0]  ent_ch
);
  localparam int IDX_W = $clog2(NUM_REQ);
  localparam int HIGH_ENTRIES = NUM_REQ - LOW_ENTRIES;
  localparam logic [15:0] A_SPAN = 16'(4 * LOW_ENTRIES);
  localparam logic [15:0] B_SPAN = 16'(4 * HIGH_ENTRIES);
  localparam logic [5:0]  CH_LIM = 6'(NUM_CH);

  logic [15:0]      off_a, off_b;
  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;

  assign off_a = addr - WIN_A_BASE;
  assign off_b = addr - WIN_B_BASE;

  always_comb begin
    sel_ok  = 1'b0;
    sel_idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= WIN_A_BASE && off_a < A_SPAN) begin
        sel_ok  = 1'b1;
        sel_idx = IDX_W'(off_a[15:2]);
      end else if (addr >= WIN_B_BASE && off_b < B_SPAN) begin
        sel_ok  = 1'b1;
        sel_idx = IDX_W'(LOW_ENTRIES) + IDX_W'(off_b[15:2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_ch  <= '0;
      err     <= 1'b0;
    end else begin
      err <= wr && sel_ok && wdata[7] && ({1'b0, wdata[CH_BITS-1:0]} >= CH_LIM);
      if (wr && sel_ok) begin
        ent_vld[sel_idx] <= wdata[7];
        ent_ch[sel_idx]  <= wdata[CH_BITS-1:0];
      end
    end
  end

  assign rdata = sel_ok ? {ent_vld[sel_idx], 2'b00, ent_ch[sel_idx]} : 8'h00;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr)); // R10
endmodule

// File: rtl/chan_events.sv
module chan_events
  import req_router_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REQ-1:0]               lvl_i,
  input  logic [NUM_REQ-1:0]               rise_i,
  input  logic [NUM_REQ-1:0]               fall_i,
  input  logic [NUM_REQ-1:0]               ent_vld,
  input  logic [NUM_REQ-1:0][CH_BITS-1:0]  ent_ch,
  output logic [NUM_CH-1:0]                act_o,
  output logic [NUM_CH-1:0]                set_o,
  output logic [NUM_CH-1:0]                clr_o,
  output logic [NUM_CH-1:0]                eor_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_REQ-1:0] hit;
    logic any_lvl, any_rise, any_fall, set_d;

    always_comb begin
      for (int i = 0; i < NUM_REQ; i++)
        hit[i] = ent_vld[i] && (ent_ch[i] == CH_BITS'(c));
    end

    assign any_lvl  = |(lvl_i & hit);
    assign any_rise = |(rise_i & hit);
    assign any_fall = |(fall_i & hit);
    assign set_d    = any_rise && !act_o[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_o[c] <= 1'b0;
        set_o[c] <= 1'b0;
        clr_o[c] <= 1'b0;
        eor_o[c] <= 1'b0;
      end else begin
        act_o[c] <= any_lvl;
        set_o[c] <= set_d;
        clr_o[c] <= ((any_rise && act_o[c]) || any_fall) && !set_d;
        eor_o[c] <= any_fall && act_o[c];
      end
    end

    AST_SET_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      set_o[c] |-> !$past(act_o[c])); // R7
    AST_SET_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      set_o[c] |-> act_o[c]); // R6
    AST_EOR_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      eor_o[c] |-> $past(act_o[c])); // R9
    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_o[c] && clr_o[c])); // R8
  end
endmodule

// File: rtl/req_router.sv
module req_router
  import req_router_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               map_err,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_active,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_set
);
  logic [NUM_REQ-1:0]              rise, fall, ent_vld;
  logic [NUM_REQ-1:0][CH_BITS-1:0] ent_ch;

  map_table #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_map (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .err(map_err), .ent_vld(ent_vld), .ent_ch(ent_ch)
  );

  req_edge #(.N(NUM_REQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(req_in), .rise_o(rise), .fall_o(fall)
  );

  chan_events #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_ev (
    .clk(clk), .rst_n(rst_n), .lvl_i(req_in), .rise_i(rise), .fall_i(fall),
    .ent_vld(ent_vld), .ent_ch(ent_ch),
    .act_o(ch_active), .set_o(ras_set), .clr_o(ras_clr), .eor_o(eor_set)
  );
endmodule

// File: tb/req_router_tb.sv
module req_router_tb;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          map_err;
  logic [NR-1:0] req_in = '0;
  logic [NC-1:0] ch_active, ras_set, ras_clr, eor_set;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  req_router #(.NUM_REQ(NR), .NUM_CH(NC)) u_dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ent_addr(input int n);
    return (n < 64) ? 16'(16'h0100 + 4 * n) : 16'(16'h1100 + 4 * (n - 64));
  endfunction

  task automatic wr_raw(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic chk_outs(input string tag, input logic [NC-1:0] a, input logic [NC-1:0] s,
                          input logic [NC-1:0] c, input logic [NC-1:0] e);
    chk({tag, " ch_active"}, 32'(ch_active), 32'(a));
    chk({tag, " ras_set"},   32'(ras_set),   32'(s));
    chk({tag, " ras_clr"},   32'(ras_clr),   32'(c));
    chk({tag, " eor_set"},   32'(eor_set),   32'(e));
  endtask

  task automatic t_reset;
    chk_outs("R4 reset", '0, '0, '0, '0);
    chk("R4 map_err", 32'(map_err), 0);
    rd_chk("R4 entry0", ent_addr(0), 8'h00);
    rd_chk("R4 entry74", ent_addr(74), 8'h00);
  endtask

  task automatic t_map;
    wr_raw(ent_addr(5), 8'hFF);
    chk("R10 err on ch31", 32'(map_err), 1);
    rd_chk("R1 R2 entry5", ent_addr(5), 8'h9F);
    wr_raw(ent_addr(70), 8'h83);
    rd_chk("R3 entry70", ent_addr(70), 8'h83);
    rd_chk("R3 entry64 untouched", ent_addr(64), 8'h00);
    wr_raw(16'h0200, 8'h81);
    wr_raw(16'h1101, 8'h81);
    rd_chk("R3 outside read", 16'h0200, 8'h00);
    rd_chk("R3 entry64 after stray", ent_addr(64), 8'h00);
    rd_chk("R2 entry0 after stray", ent_addr(0), 8'h00);
  endtask

  task automatic t_invalid;
    wr_raw(ent_addr(10), 8'h03);
    chk("R10 no err invalid", 32'(map_err), 0);
    @(negedge clk); req_in[10] = 1'b1;
    @(negedge clk); chk_outs("R5 rise ignored", '0, '0, '0, '0);
    req_in[10] = 1'b0;
    @(negedge clk); chk_outs("R5 fall ignored", '0, '0, '0, '0);
  endtask

  task automatic t_events;
    logic [NC-1:0] b2;
    b2 = NC'(1) << 2;
    wr_raw(ent_addr(5), 8'h82);
    chk("R10 no err ch2", 32'(map_err), 0);
    wr_raw(ent_addr(70), 8'h82);
    @(negedge clk); req_in[5] = 1'b1;
    @(negedge clk); chk_outs("R7 rise idle", b2, b2, '0, '0);
    @(negedge clk); chk_outs("R11 R6 held", b2, '0, '0, '0);
    @(negedge clk); chk_outs("R11 held2", b2, '0, '0, '0);
    req_in[70] = 1'b1;
    @(negedge clk); chk_outs("R8 rise busy", b2, '0, b2, '0);
    req_in[70] = 1'b0;
    @(negedge clk); chk_outs("R8 R9 fall shared", b2, '0, b2, b2);
    req_in[5] = 1'b0;
    @(negedge clk); chk_outs("R9 R6 last fall", '0, '0, b2, b2);
    @(negedge clk); chk_outs("R11 idle", '0, '0, '0, '0);
  endtask

  task automatic t_badch;
    wr_raw(ent_addr(20), 8'h94);
    chk("R10 err ch20", 32'(map_err), 1);
    @(negedge clk);
    chk("R10 err pulse ends", 32'(map_err), 0);
    rd_chk("R10 stored", ent_addr(20), 8'h94);
    wr_raw(ent_addr(21), 8'h8F);
    chk("R10 no err ch15", 32'(map_err), 0);
    req_in[20] = 1'b1;
    @(negedge clk); chk_outs("R10 bad ch no output", '0, '0, '0, '0);
    req_in[20] = 1'b0;
    @(negedge clk); chk_outs("R10 bad ch fall", '0, '0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_invalid();
    t_events();
    t_badch();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule